// File: doc/BRIEF.md
# SPI Offload Register and Interrupt Block

This block is the register face of an SPI command engine. A host reaches it through a plain 32-bit register read/write port, and an engine behind it consumes commands and transmit bytes and returns received bytes. Three FIFOs sit inside the block:
- one holds 16-bit engine commands;
- one holds transmit bytes;
- one holds receive bytes.

The host fills the two outbound queues, drains the inbound one (with a pop or with a non-destructive peek), and checks how much room or fill each queue has.

Four interrupt causes are tracked:
- the command queue running low;
- the transmit queue running low;
- the receive queue running high;
- the engine reaching a sync instruction.

A sync event also stores the instruction's 8-bit identifier. Software reads it back to learn which command program has completed. A soft-reset register holds the engine and all three queues in reset until it is cleared. The block comes out of hardware reset with that soft reset asserted.

Top module: `spio_regblk`

## Requirements
- R1: A read of offset 0x00 returns 0x00010201. The major number 1 is in bits [23:16], the minor number 2 in [15:8] and the patch number 1 in [7:0].
- R2: Bit 0 of offset 0x40 is the soft reset. It reads 1 after hardware reset. While it is 1, `engine_rst` is high, all three queues are emptied, host pushes are dropped and sync events are ignored. Writing 0 releases the reset.
- R3: A write to 0xE0 pushes wdata[15:0] into the command queue. The push is dropped when the queue is full. A read of 0xD0 returns the free entries (depth minus fill).
- R4: A write to 0xE4 pushes wdata[7:0] into the transmit queue. The push is dropped when the queue is full. A read of 0xD4 returns its free entries.
- R5: A read of 0xD8 returns the receive fill level. A read of 0xE8 returns the head byte and removes it. A read of 0xEC returns the head byte and leaves the queue unchanged. Both reads return 0 when the queue is empty.
- R6: Offset 0x80 holds the enable bits [3:0]. `irq` is high exactly when some bit of pending AND enable is set. A read of 0x88 returns pending AND enable.
- R7: The pending bits are read at 0x84. Each bit is set on the clock after its cause is seen:
  - bit 0: command fill ≤ depth/4;
  - bit 1: transmit fill ≤ depth/4;
  - bit 2: receive fill ≥ depth − depth/4;
  - bit 3: sync event.
  Once set, a bit stays set until it is cleared.
- R8: Writing a 1 to a bit of 0x84 clears that pending bit. A cause that is still present on the same clock wins, so a level-caused bit whose condition persists stays set. Writing 0xFF clears every bit whose cause is absent.
- R9: `sync_valid` outside soft reset sets pending bit 3 and, on the same clock edge, loads `sync_id` into the register read at 0xC0.
- R10: `rdata` is loaded on the clock edge that samples `rd_en` and holds until the next read. Unmapped offsets read 0.
- R11: The command and transmit queue heads appear on `cmd_data`/`sdo_data`. Their `*_valid` signal is high when the queue is non-empty and not in reset, and an entry leaves on valid AND ready. `sdi_ready` is high when the receive queue is not full and not in reset. A byte is stored on `sdi_valid` AND `sdi_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| engine_rst | output | 1 | Soft reset to the engine |
| cmd_valid | output | 1 | Command queue head valid |
| cmd_data | output | 16 | Command queue head |
| cmd_ready | input | 1 | Engine takes a command |
| sdo_valid | output | 1 | Transmit queue head valid |
| sdo_data | output | 8 | Transmit queue head |
| sdo_ready | input | 1 | Engine takes a transmit byte |
| sdi_valid | input | 1 | Engine offers a received byte |
| sdi_data | input | 8 | Received byte |
| sdi_ready | output | 1 | Receive queue can accept |
| sync_valid | input | 1 | Engine reached a sync instruction |
| sync_id | input | 8 | Identifier of that sync instruction |

## Verification
The assertions assume the host never raises `rd_en` and `wr_en` on the same clock. They also assume `sync_valid` is a single-cycle pulse with `sync_id` stable during it. The stimulus keeps to this: every register access is a one-cycle strobe issued by a task that does one access at a time, and sync pulses last exactly one clock. The engine-side strobes (`cmd_ready`, `sdo_ready`, `sdi_valid`) may coincide with host accesses. The reference model applies the pre-edge fill levels to all of them, so simultaneous push and pop are allowed.

// File: rtl/spio_pkg.sv
package spio_pkg;

    localparam int unsigned IRQ_W = 4;

    localparam logic [7:0] OFS_VERSION = 8'h00;
    localparam logic [7:0] OFS_SRST    = 8'h40;
    localparam logic [7:0] OFS_IRQ_EN  = 8'h80;
    localparam logic [7:0] OFS_IRQ_PND = 8'h84;
    localparam logic [7:0] OFS_IRQ_SRC = 8'h88;
    localparam logic [7:0] OFS_SYNC    = 8'hC0;
    localparam logic [7:0] OFS_CMD_RM  = 8'hD0;
    localparam logic [7:0] OFS_TX_RM   = 8'hD4;
    localparam logic [7:0] OFS_RX_LVL  = 8'hD8;
    localparam logic [7:0] OFS_CMD_PUSH = 8'hE0;
    localparam logic [7:0] OFS_TX_PUSH  = 8'hE4;
    localparam logic [7:0] OFS_RX_POP   = 8'hE8;
    localparam logic [7:0] OFS_RX_PEEK  = 8'hEC;

    // interrupt bit positions (software decodes these)
    localparam int unsigned IB_CMD_LOW  = 0;
    localparam int unsigned IB_TX_LOW   = 1;
    localparam int unsigned IB_RX_HIGH  = 2;
    localparam int unsigned IB_SYNC     = 3;

    typedef struct packed {
        logic        srst;
        logic [7:0]  sync_id;
        logic [31:0] rdata;
    } spio_regs_t;

    typedef struct packed {
        logic [IRQ_W-1:0] pend;
        logic [IRQ_W-1:0] en;
    } spio_irq_t;

endpackage

// File: rtl/spio_fifo.sv
module spio_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != FULL_CNT) && !flush;
        do_pop  = pop && (st_q.cnt != '0) && !flush;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = (st_q.wp == LAST_PTR) ? '0 : st_q.wp + 1'b1;
            if (do_pop)  st_d.rp = (st_q.rp == LAST_PTR) ? '0 : st_q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= push_data;
    end

    assign head  = mem_q[st_q.rp];
    assign count = st_q.cnt;

    // R3: fill never exceeds depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    // R5: an empty queue with no push stays empty
    a_r5_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !push) |=> st_q.cnt == '0);

    // R2: flush always empties the queue
    a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> st_q.cnt == '0);

endmodule

// File: rtl/spio_irq.sv
module spio_irq
    import spio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] cause,
    input  logic [IRQ_W-1:0] clr,
    input  logic             en_we,
    input  logic [IRQ_W-1:0] en_wdata,
    output logic [IRQ_W-1:0] pend,
    output logic [IRQ_W-1:0] en,
    output logic             irq
);

    spio_irq_t ir_d, ir_q;

    always_comb begin
        ir_d      = ir_q;
        ir_d.pend = (ir_q.pend & ~clr) | cause;
        if (en_we) ir_d.en = en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign pend = ir_q.pend;
    assign en   = ir_q.en;
    assign irq  = |(ir_q.pend & ir_q.en);

    // R7: a seen cause is pending on the next clock
    a_r7_cause_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cause != '0) |=> ((ir_q.pend & $past(cause)) == $past(cause)));

    // R8: a cleared bit with no cause present drops
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~cause) != '0) |=> ((ir_q.pend & $past(clr & ~cause)) == '0));

    // R7: without cause or clear, pending is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cause == '0 && clr == '0) |=> $stable(ir_q.pend));

endmodule

// File: rtl/spio_regblk.sv
module spio_regblk
    import spio_pkg::*;
#(
    parameter int unsigned CMD_DEPTH = 8,
    parameter int unsigned TX_DEPTH  = 8,
    parameter int unsigned RX_DEPTH  = 8,
    parameter logic [7:0]  VER_MINOR = 8'd2,
    parameter logic [7:0]  VER_PATCH = 8'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  addr,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        rd_en,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        engine_rst,
    output logic        cmd_valid,
    output logic [15:0] cmd_data,
    input  logic        cmd_ready,
    output logic        sdo_valid,
    output logic [7:0]  sdo_data,
    input  logic        sdo_ready,
    input  logic        sdi_valid,
    input  logic [7:0]  sdi_data,
    output logic        sdi_ready,
    input  logic        sync_valid,
    input  logic [7:0]  sync_id
);

    localparam int unsigned CMD_CW = $clog2(CMD_DEPTH + 1);
    localparam int unsigned TX_CW  = $clog2(TX_DEPTH + 1);
    localparam int unsigned RX_CW  = $clog2(RX_DEPTH + 1);
    localparam logic [CMD_CW-1:0] CMD_FULL = CMD_CW'(CMD_DEPTH);
    localparam logic [TX_CW-1:0]  TX_FULL  = TX_CW'(TX_DEPTH);
    localparam logic [RX_CW-1:0]  RX_FULL  = RX_CW'(RX_DEPTH);
    localparam logic [CMD_CW-1:0] CMD_LOW  = CMD_CW'(CMD_DEPTH / 4);
    localparam logic [TX_CW-1:0]  TX_LOW   = TX_CW'(TX_DEPTH / 4);
    localparam logic [RX_CW-1:0]  RX_HIGH  = RX_CW'(RX_DEPTH - RX_DEPTH / 4);
    localparam logic [31:0]       VERSION  = {8'h00, 8'd1, VER_MINOR, VER_PATCH};

    spio_regs_t rg_d, rg_q;

    logic [CMD_CW-1:0] cmd_cnt;
    logic [TX_CW-1:0]  tx_cnt;
    logic [RX_CW-1:0]  rx_cnt;
    logic [7:0]        rx_head;
    logic [IRQ_W-1:0]  irq_cause, irq_clr, irq_pend, irq_en;
    logic              cmd_push, tx_push, rx_push, cmd_pop, tx_pop, rx_pop;
    logic              sync_ok, en_we;
    logic [31:0]       rx_word;
    logic              unused_hi;

    assign unused_hi = ^wdata[31:16];

    // queue strobes
    assign cmd_push = wr_en && (addr == OFS_CMD_PUSH) && !rg_q.srst;
    assign tx_push  = wr_en && (addr == OFS_TX_PUSH)  && !rg_q.srst;
    assign rx_pop   = rd_en && (addr == OFS_RX_POP)   && !rg_q.srst;
    assign cmd_pop  = cmd_valid && cmd_ready;
    assign tx_pop   = sdo_valid && sdo_ready;
    assign rx_push  = sdi_valid && sdi_ready;
    assign sync_ok  = sync_valid && !rg_q.srst;

    assign cmd_valid  = (cmd_cnt != '0) && !rg_q.srst;
    assign sdo_valid  = (tx_cnt != '0) && !rg_q.srst;
    assign sdi_ready  = (rx_cnt != RX_FULL) && !rg_q.srst;
    assign engine_rst = rg_q.srst;
    assign rdata      = rg_q.rdata;
    assign rx_word    = (rx_cnt == '0) ? 32'h0 : {24'h0, rx_head};

    spio_fifo #(.W(16), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk(clk), .rst_n(rst_n), .flush(rg_q.srst),
        .push(cmd_push), .push_data(wdata[15:0]),
        .pop(cmd_pop), .head(cmd_data), .count(cmd_cnt)
    );

    spio_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .flush(rg_q.srst),
        .push(tx_push), .push_data(wdata[7:0]),
        .pop(tx_pop), .head(sdo_data), .count(tx_cnt)
    );

    spio_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .flush(rg_q.srst),
        .push(rx_push), .push_data(sdi_data),
        .pop(rx_pop), .head(rx_head), .count(rx_cnt)
    );

    // interrupt causes, indexed by the bit software decodes
    always_comb begin
        irq_cause              = '0;
        irq_cause[IB_CMD_LOW]  = (cmd_cnt <= CMD_LOW);
        irq_cause[IB_TX_LOW]   = (tx_cnt <= TX_LOW);
        irq_cause[IB_RX_HIGH]  = (rx_cnt >= RX_HIGH);
        irq_cause[IB_SYNC]     = sync_ok;
        irq_clr = (wr_en && addr == OFS_IRQ_PND) ? wdata[IRQ_W-1:0] : '0;
        en_we   = wr_en && (addr == OFS_IRQ_EN);
    end

    spio_irq u_irq (
        .clk(clk), .rst_n(rst_n), .cause(irq_cause), .clr(irq_clr),
        .en_we(en_we), .en_wdata(wdata[IRQ_W-1:0]),
        .pend(irq_pend), .en(irq_en), .irq(irq)
    );

    always_comb begin
        rg_d = rg_q;
        if (wr_en && addr == OFS_SRST) rg_d.srst = wdata[0];
        if (sync_ok) rg_d.sync_id = sync_id;
        if (rd_en) begin
            case (addr)
                OFS_VERSION: rg_d.rdata = VERSION;
                OFS_SRST:    rg_d.rdata = {31'h0, rg_q.srst};
                OFS_IRQ_EN:  rg_d.rdata = 32'(irq_en);
                OFS_IRQ_PND: rg_d.rdata = 32'(irq_pend);
                OFS_IRQ_SRC: rg_d.rdata = 32'(irq_pend & irq_en);
                OFS_SYNC:    rg_d.rdata = {24'h0, rg_q.sync_id};
                OFS_CMD_RM:  rg_d.rdata = 32'(CMD_FULL - cmd_cnt);
                OFS_TX_RM:   rg_d.rdata = 32'(TX_FULL - tx_cnt);
                OFS_RX_LVL:  rg_d.rdata = 32'(rx_cnt);
                OFS_RX_POP:  rg_d.rdata = rx_word;
                OFS_RX_PEEK: rg_d.rdata = rx_word;
                default:     rg_d.rdata = 32'h0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q       <= '0;
            rg_q.srst  <= 1'b1;
        end else begin
            rg_q <= rg_d;
        end
    end

    // R9: a sync outside reset raises bit 3 and captures its ID together
    a_r9_sync_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_valid && !engine_rst) |=> (irq_pend[IB_SYNC] && rg_q.sync_id == $past(sync_id)));

    // R9: ignored sync leaves the ID unchanged
    a_r9_sync_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_valid || engine_rst) |=> $stable(rg_q.sync_id));

    // R5: a peek does not change the receive fill
    a_r5_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_RX_PEEK && !rx_push && !engine_rst) |=> $stable(rx_cnt));

    // R10: read data changes only after a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R11: engine sees nothing while held in reset
    a_r11_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        engine_rst |=> (!cmd_valid && !sdo_valid));

endmodule

// File: tb/spio_regblk_tb_top.sv
module spio_regblk_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr;
    logic        wr_en, rd_en;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq, engine_rst;
    logic        cmd_valid, cmd_ready, sdo_valid, sdo_ready;
    logic [15:0] cmd_data;
    logic [7:0]  sdo_data, sdi_data, sync_id;
    logic        sdi_valid, sdi_ready, sync_valid;

    always #2 clk = ~clk;

    spio_regblk dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .irq(irq), .engine_rst(engine_rst),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .sdo_valid(sdo_valid), .sdo_data(sdo_data), .sdo_ready(sdo_ready),
        .sdi_valid(sdi_valid), .sdi_data(sdi_data), .sdi_ready(sdi_ready),
        .sync_valid(sync_valid), .sync_id(sync_id)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    localparam int DEP = 8;
    int          q_cmd[$];
    int          q_tx[$];
    int          q_rx[$];
    logic [3:0]  m_en, m_pend;
    bit          m_srst;
    logic [7:0]  m_sync;
    logic [31:0] m_rdata;

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h00: return 32'h0001_0201;
            8'h40: return {31'h0, m_srst};
            8'h80: return {28'h0, m_en};
            8'h84: return {28'h0, m_pend};
            8'h88: return {28'h0, m_pend & m_en};
            8'hC0: return {24'h0, m_sync};
            8'hD0: return 32'(DEP - q_cmd.size());
            8'hD4: return 32'(DEP - q_tx.size());
            8'hD8: return 32'(q_rx.size());
            8'hE8, 8'hEC: return (q_rx.size() == 0) ? 32'h0 : 32'(q_rx[0]);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int nc, nt, nr;
        logic [3:0] cause, clr;
        bit rx_rdy;
        if (!rst_n) begin
            q_cmd.delete(); q_tx.delete(); q_rx.delete();
            m_en = 0; m_pend = 0; m_srst = 1; m_sync = 0; m_rdata = 0;
        end else begin
            nc = q_cmd.size(); nt = q_tx.size(); nr = q_rx.size();
            rx_rdy = (nr < DEP) && !m_srst;
            if (rd_en) m_rdata = m_read(addr);
            cause = {sync_valid && !m_srst, nr >= 6, nt <= 2, nc <= 2};
            clr   = (wr_en && addr == 8'h84) ? wdata[3:0] : 4'h0;
            m_pend = (m_pend & ~clr) | cause;
            if (wr_en && addr == 8'h80) m_en = wdata[3:0];
            if (sync_valid && !m_srst) m_sync = sync_id;
            if (m_srst) begin
                q_cmd.delete(); q_tx.delete(); q_rx.delete();
            end else begin
                if (cmd_ready && nc > 0) void'(q_cmd.pop_front());
                if (wr_en && addr == 8'hE0 && nc < DEP) q_cmd.push_back(int'(wdata[15:0]));
                if (sdo_ready && nt > 0) void'(q_tx.pop_front());
                if (wr_en && addr == 8'hE4 && nt < DEP) q_tx.push_back(int'(wdata[7:0]));
                if (rd_en && addr == 8'hE8 && nr > 0) void'(q_rx.pop_front());
                if (sdi_valid && rx_rdy) q_rx.push_back(int'(sdi_data));
            end
            if (wr_en && addr == 8'h40) m_srst = wdata[0];
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk("R6 irq", {31'h0, irq}, {31'h0, |(m_pend & m_en)});
            chk("R2 engine_rst", {31'h0, engine_rst}, {31'h0, m_srst});
            chk("R11 cmd_valid", {31'h0, cmd_valid}, {31'h0, q_cmd.size() > 0 && !m_srst});
            if (cmd_valid) chk("R11 cmd_data", {16'h0, cmd_data}, 32'(q_cmd[0]));
            chk("R11 sdo_valid", {31'h0, sdo_valid}, {31'h0, q_tx.size() > 0 && !m_srst});
            if (sdo_valid) chk("R11 sdo_data", {24'h0, sdo_data}, 32'(q_tx[0]));
            chk("R11 sdi_ready", {31'h0, sdi_ready}, {31'h0, q_rx.size() < DEP && !m_srst});
            chk("R10 rdata", rdata, m_rdata);
        end
    end

    // ---------------- stimulus helpers (called at a negedge) ----------------
    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, string tag, logic [31:0] exp);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; addr = 0; wdata = 0; wr_en = 0; rd_en = 0;
        cmd_ready = 0; sdo_ready = 0; sdi_valid = 0; sdi_data = 0;
        sync_valid = 0; sync_id = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R2 reset engine_rst", {31'h0, engine_rst}, 32'h1);
        chk("R6 reset irq", {31'h0, irq}, 32'h0);
        rd(8'h00, "R1 version", 32'h0001_0201);
        rd(8'h40, "R2 srst reads 1", 32'h1);
        wr(8'hE0, 32'h1111);
        rd(8'hD0, "R2 push dropped in reset", 32'd8);
        wr(8'h40, 32'h0);
        rd(8'h40, "R2 released", 32'h0);
        // command queue
        wr(8'hE0, 32'h1001); wr(8'hE0, 32'h1002); wr(8'hE0, 32'h1003);
        rd(8'hD0, "R3 room after 3", 32'd5);
        for (int i = 4; i <= 10; i++) wr(8'hE0, 32'h1000 + i);
        rd(8'hD0, "R3 full room", 32'd0);
        chk("R11 cmd head", {16'h0, cmd_data}, 32'h1001);
        cmd_ready = 1; repeat (6) @(negedge clk); cmd_ready = 0;
        chk("R3 overflow dropped, head", {16'h0, cmd_data}, 32'h1007);
        rd(8'hD0, "R3 room after pops", 32'd6);
        // transmit queue
        wr(8'hE4, 32'hA1); wr(8'hE4, 32'hA2);
        rd(8'hD4, "R4 tx room", 32'd6);
        chk("R4 tx head", {24'h0, sdo_data}, 32'hA1);
        rd(8'h84, "R7 low-water bits", 32'h3);
        wr(8'h80, 32'h4);
        chk("R6 masked irq", {31'h0, irq}, 32'h0);
        // receive queue
        sdi_valid = 1;
        for (int i = 0; i < 7; i++) begin
            sdi_data = 8'hC0 + 8'(i);
            @(negedge clk);
        end
        sdi_valid = 0;
        rd(8'hD8, "R5 rx level", 32'd7);
        rd(8'h84, "R7 rx high bit", 32'h7);
        chk("R6 irq on enabled bit", {31'h0, irq}, 32'h1);
        rd(8'h88, "R6 source", 32'h4);
        rd(8'hEC, "R5 peek", 32'hC0);
        rd(8'hEC, "R5 peek again", 32'hC0);
        rd(8'hD8, "R5 peek keeps level", 32'd7);
        wr(8'h84, 32'h4);
        rd(8'h84, "R8 cause holds bit", 32'h7);
        rd(8'hE8, "R5 pop first", 32'hC0);
        rd(8'hE8, "R5 pop second", 32'hC1);
        wr(8'h84, 32'h4);
        rd(8'h84, "R8 cleared", 32'h3);
        chk("R6 irq dropped", {31'h0, irq}, 32'h0);
        // sync
        wr(8'h80, 32'h8);
        sync_id = 8'hA5; sync_valid = 1; @(negedge clk); sync_valid = 0;
        rd(8'hC0, "R9 sync id", 32'hA5);
        rd(8'h84, "R9 sync pending", 32'hB);
        rd(8'h88, "R6 sync source", 32'h8);
        chk("R6 sync irq", {31'h0, irq}, 32'h1);
        wr(8'h84, 32'hFF);
        rd(8'h84, "R8 clear all", 32'h3);
        rd(8'h44, "R10 unmapped", 32'h0);
        // soft reset flush, sync ignored
        wr(8'h40, 32'h1);
        chk("R2 engine_rst again", {31'h0, engine_rst}, 32'h1);
        sync_id = 8'h3C; sync_valid = 1; @(negedge clk); sync_valid = 0;
        wr(8'h40, 32'h0);
        rd(8'hC0, "R9 sync ignored in reset", 32'hA5);
        rd(8'hD8, "R2 rx flushed", 32'd0);
        rd(8'hD0, "R2 cmd flushed", 32'd8);
        rd(8'hD4, "R2 tx flushed", 32'd8);
        rd(8'hE8, "R5 empty pop", 32'h0);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule